// File: doc/BRIEF.md
# Packed Weight Streamer

The block reads several logical weight buffers that share one dual-port RAM and turns each buffer into a repeating valid/ready word stream. It runs in a memory clock that is faster than the compute clock that consumes the streams. Each RAM port is time-shared among the buffers assigned to it. A round-robin arbiter on each port issues at most one read per cycle. It skips any buffer whose small output queue has no room, counting reads still in flight. Any slot a stalled stream does not use therefore goes to another buffer on the same port.

One logical buffer is stored split: its even-indexed words sit in one RAM region and are read through port A, and its odd-indexed words sit in another region and are read through port B. A merging stage puts the two halves back into their original order. Every buffer is read from its start address to its last word and then wraps, so the compute side sees the same weight sequence over and over. The RAM is loaded through a one-word-per-cycle write port that shares RAM port A. The per-buffer streams are meant to feed clock-crossing FIFOs, which are not part of this block.

Top module: `wstream_top`

## Requirements
- R1: While reset is high and afterwards until enabled, every `out_valid` bit is low. The first word each stream delivers after `stream_en` rises is word 0 of its buffer.
- R2: Stream 1 delivers the 7-word buffer stored at RAM addresses 8..14, and stream 2 delivers the 4-word buffer at addresses 24..27. Each goes in ascending address order and wraps to its first word after the last.
- R3: Stream 0 delivers a 10-word buffer whose word 2i is stored at address i (0..4, read through port A) and whose word 2i+1 is stored at address 16+i (16..20, read through port B). The words come out in order 0,1,...,9 and then wrap.
- R4: While an output is valid and its ready is low, the valid stays high and the data stays unchanged on the next cycle.
- R5: Port A serves streams 0-even and 1, and port B serves streams 0-odd and 2, each port reading at most once per cycle in round-robin order. With every ready held high, over a 200-cycle steady-state window streams 1 and 2 each deliver 95..105 words and stream 0 delivers 190..200.
- R6: When stream 0's ready is held low, its read slots are given to the other buffer on each port. Over a 200-cycle window streams 1 and 2 each deliver at least 190 words, and stream 0 delivers none.
- R7: Under random backpressure on all streams, no word is lost, duplicated or reordered, and no per-lane queue ever holds more than 4 words.
- R8: While `stream_en` is low no RAM read is issued. Once the queues have drained, no output is valid.
- R9: A cycle with `init_we` high writes `init_data` to `init_addr` through port A and blocks port A reads in that cycle. Port B reads continue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| stream_en | input | 1 | Allows RAM reads for streaming |
| init_we | input | 1 | RAM preload write strobe (port A) |
| init_addr | input | 5 | RAM preload address |
| init_data | input | 8 | RAM preload data |
| out_ready | input | 3 | Per-stream consumer ready |
| out_valid | output | 3 | Per-stream word valid |
| out_data | output | 24 | Per-stream words, stream k in bits 8k+7..8k |

## Verification
The hardest state to reach from the ports is slot reallocation. It happens only once the stalled stream's two lane queues, one on each port, have filled to their credit limit, and only then does each arbiter hand every slot to the other buffer. The bench holds stream 0's ready low for a long warm-up before it counts, so both split lanes are full and both ports are in the one-buffer-only regime. It then releases that stream under random backpressure, which shows the queued even and odd halves resume in order. A preload write burst during streaming blocks port A alone while port B continues.

// File: rtl/wstream_pkg.sv
`timescale 1ns/1ps
package wstream_pkg;
    localparam int DATA_W          = 8;
    localparam int ADDR_W          = 5;
    localparam int NPORT           = 2;
    localparam int NLANE           = 4;
    localparam int NOUT            = 3;
    localparam int LANE_FIFO_DEPTH = 4;
    localparam int LANE_W          = $clog2(NLANE);
    localparam int CNT_W           = $clog2(LANE_FIFO_DEPTH + 1);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LANE_W-1:0] lane_idx_t;

    typedef struct packed {
        logic      valid;
        lane_idx_t lane;
    } rd_tag_t;

    // RAM port that reads a lane
    function automatic int lane_port(input int l);
        case (l)
            0, 1:    return 0;
            default: return 1;
        endcase
    endfunction

    // first RAM address of a lane
    function automatic int lane_base(input int l);
        case (l)
            0:       return 0;
            1:       return 8;
            2:       return 16;
            default: return 24;
        endcase
    endfunction

    // number of words in a lane
    function automatic int lane_len(input int l);
        case (l)
            0:       return 5;
            1:       return 7;
            2:       return 5;
            default: return 4;
        endcase
    endfunction

    // output stream fed by a single lane or by an even/odd lane pair
    function automatic bit out_split(input int o);
        return (o == 0);
    endfunction

    function automatic int out_even_lane(input int o);
        case (o)
            0:       return 0;
            1:       return 1;
            default: return 3;
        endcase
    endfunction

    function automatic int out_odd_lane(input int o);
        return (o == 0) ? 2 : out_even_lane(o);
    endfunction
endpackage

// File: rtl/wstream_dpram.sv
`timescale 1ns/1ps
module wstream_dpram #(
    parameter int AW = 5,
    parameter int DW = 8,
    localparam int WORDS = 1 << AW
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic [AW-1:0] b_addr,
    output logic [DW-1:0] b_rdata
);
    logic [DW-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (a_we) begin
            cells[a_addr] <= a_wdata;
        end
        a_rdata <= cells[a_addr];
    end

    always_ff @(posedge clk) begin
        b_rdata <= cells[b_addr];
    end
endmodule

// File: rtl/wstream_rr_arb.sv
`timescale 1ns/1ps
module wstream_rr_arb #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] last_q;

    // search starts one past the previous winner
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        for (int k = 1; k <= N; k++) begin
            if (gnt == '0 && req[IW'((int'(last_q) + k) % N)]) begin
                gnt[IW'((int'(last_q) + k) % N)] = 1'b1;
                gnt_idx = IW'((int'(last_q) + k) % N);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= IW'(N - 1);
        end else if (|gnt) begin
            last_q <= gnt_idx;
        end
    end
endmodule

// File: rtl/wstream_lane.sv
`timescale 1ns/1ps
module wstream_lane #(
    parameter int AW    = 5,
    parameter int DW    = 8,
    parameter int BASE  = 0,
    parameter int LEN   = 4,
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          grant,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          pop,
    output logic          req,
    output logic [AW-1:0] rd_addr,
    output logic          head_valid,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] fill
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int IW = (LEN > 1) ? $clog2(LEN) : 1;

    logic [DW-1:0] store [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic [IW-1:0] idx;
    logic          take;

    // room for the word arriving now plus the one a new read would bring
    assign req        = en && (int'(cnt) + int'(wr_valid) + 1 <= DEPTH);
    assign rd_addr    = AW'(BASE) + AW'(idx);
    assign head_valid = (cnt != '0);
    assign head_data  = store[rp];
    assign fill       = cnt;
    assign take       = pop && head_valid;

    always_ff @(posedge clk) begin
        if (wr_valid) begin
            store[wp] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
            idx <= '0;
        end else begin
            if (grant) begin
                idx <= (int'(idx) == LEN - 1) ? '0 : idx + 1'b1;
            end
            if (wr_valid) begin
                wp <= (int'(wp) == DEPTH - 1) ? '0 : wp + 1'b1;
            end
            if (take) begin
                rp <= (int'(rp) == DEPTH - 1) ? '0 : rp + 1'b1;
            end
            cnt <= cnt + CW'(wr_valid) - CW'(take);
        end
    end
endmodule

// File: rtl/wstream_split_merge.sv
`timescale 1ns/1ps
module wstream_split_merge #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          even_valid,
    input  logic [DW-1:0] even_data,
    input  logic          odd_valid,
    input  logic [DW-1:0] odd_data,
    input  logic          out_ready,
    output logic          even_pop,
    output logic          odd_pop,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    logic odd_turn;

    assign out_valid = odd_turn ? odd_valid : even_valid;
    assign out_data  = odd_turn ? odd_data  : even_data;
    assign even_pop  = !odd_turn && even_valid && out_ready;
    assign odd_pop   = odd_turn && odd_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            odd_turn <= 1'b0;
        end else if (out_valid && out_ready) begin
            odd_turn <= !odd_turn;
        end
    end
endmodule

// File: rtl/wstream_top.sv
`timescale 1ns/1ps
module wstream_top
    import wstream_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   stream_en,
    input  logic                   init_we,
    input  logic [ADDR_W-1:0]      init_addr,
    input  logic [DATA_W-1:0]      init_data,
    input  logic [NOUT-1:0]        out_ready,
    output logic [NOUT-1:0]        out_valid,
    output logic [NOUT*DATA_W-1:0] out_data
);
    logic [NLANE-1:0]              lane_req, lane_gnt, lane_wr_valid;
    logic [NLANE-1:0]              lane_head_valid, lane_pop;
    logic [NLANE-1:0][ADDR_W-1:0]  lane_addr;
    logic [NLANE-1:0][DATA_W-1:0]  lane_head;
    logic [NLANE-1:0][CNT_W-1:0]   lane_fill;
    logic [NPORT-1:0][NLANE-1:0]   port_req, port_gnt;
    logic [NPORT-1:0][LANE_W-1:0]  port_gnt_idx;
    logic [NPORT-1:0][ADDR_W-1:0]  port_addr;
    logic [NPORT-1:0][DATA_W-1:0]  port_dout;
    rd_tag_t [NPORT-1:0]           tag_q;
    logic [NOUT-1:0]               ov;
    logic [NOUT-1:0][DATA_W-1:0]   od;
    addr_t                         ram_a_addr;

    // requests sorted onto the port that owns each lane; a preload write holds port A
    always_comb begin
        port_req = '0;
        for (int p = 0; p < NPORT; p++) begin
            for (int l = 0; l < NLANE; l++) begin
                if (lane_port(l) == p) begin
                    port_req[p][l] = lane_req[l] && !(p == 0 && init_we);
                end
            end
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        wstream_rr_arb #(.N(NLANE)) arb_i (
            .clk     (clk),
            .rst     (rst),
            .req     (port_req[p]),
            .gnt     (port_gnt[p]),
            .gnt_idx (port_gnt_idx[p])
        );
    end

    always_comb begin
        port_addr = '0;
        for (int p = 0; p < NPORT; p++) begin
            for (int l = 0; l < NLANE; l++) begin
                if (port_gnt[p][l]) begin
                    port_addr[p] = lane_addr[l];
                end
            end
        end
    end

    // lane tag travels alongside the RAM read latency
    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
        end else begin
            for (int p = 0; p < NPORT; p++) begin
                tag_q[p].valid <= |port_gnt[p];
                tag_q[p].lane  <= port_gnt_idx[p];
            end
        end
    end

    assign ram_a_addr = init_we ? init_addr : port_addr[0];

    wstream_dpram #(.AW(ADDR_W), .DW(DATA_W)) ram_i (
        .clk     (clk),
        .a_we    (init_we),
        .a_addr  (ram_a_addr),
        .a_wdata (init_data),
        .a_rdata (port_dout[0]),
        .b_addr  (port_addr[1]),
        .b_rdata (port_dout[1])
    );

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        localparam int PP = lane_port(l);

        assign lane_gnt[l]      = port_gnt[PP][l];
        assign lane_wr_valid[l] = tag_q[PP].valid && (tag_q[PP].lane == LANE_W'(l));

        wstream_lane #(
            .AW    (ADDR_W),
            .DW    (DATA_W),
            .BASE  (lane_base(l)),
            .LEN   (lane_len(l)),
            .DEPTH (LANE_FIFO_DEPTH)
        ) lane_i (
            .clk        (clk),
            .rst        (rst),
            .en         (stream_en),
            .grant      (lane_gnt[l]),
            .wr_valid   (lane_wr_valid[l]),
            .wr_data    (port_dout[PP]),
            .pop        (lane_pop[l]),
            .req        (lane_req[l]),
            .rd_addr    (lane_addr[l]),
            .head_valid (lane_head_valid[l]),
            .head_data  (lane_head[l]),
            .fill       (lane_fill[l])
        );
    end

    for (genvar o = 0; o < NOUT; o++) begin : g_out
        localparam int EL = out_even_lane(o);
        localparam int OL = out_odd_lane(o);
        if (out_split(o)) begin : g_split
            wstream_split_merge #(.DW(DATA_W)) merge_i (
                .clk        (clk),
                .rst        (rst),
                .even_valid (lane_head_valid[EL]),
                .even_data  (lane_head[EL]),
                .odd_valid  (lane_head_valid[OL]),
                .odd_data   (lane_head[OL]),
                .out_ready  (out_ready[o]),
                .even_pop   (lane_pop[EL]),
                .odd_pop    (lane_pop[OL]),
                .out_valid  (ov[o]),
                .out_data   (od[o])
            );
        end else begin : g_direct
            assign ov[o]        = lane_head_valid[EL];
            assign od[o]        = lane_head[EL];
            assign lane_pop[EL] = lane_head_valid[EL] && out_ready[o];
        end
    end

    assign out_valid = ov;
    assign out_data  = od;
endmodule

// File: rtl/wstream_chk.sv
`timescale 1ns/1ps
module wstream_chk
    import wstream_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic                        stream_en,
    input logic                        init_we,
    input logic [NOUT-1:0]             out_valid,
    input logic [NOUT-1:0]             out_ready,
    input logic [NOUT*DATA_W-1:0]      out_data,
    input logic [NPORT-1:0][NLANE-1:0] port_gnt,
    input logic [NLANE-1:0][CNT_W-1:0] lane_fill
);
    for (genvar o = 0; o < NOUT; o++) begin : g_hold
        assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
            (out_valid[o] && !out_ready[o]) |=>
            (out_valid[o] && $stable(out_data[o*DATA_W +: DATA_W])));
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assert_one_read_R5: assert property (@(posedge clk) disable iff (rst)
            $onehot0(port_gnt[p]));
    end

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
            lane_fill[l] <= CNT_W'(LANE_FIFO_DEPTH));
    end

    assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !stream_en |-> (port_gnt == '0));

    assert_init_prio_R9: assert property (@(posedge clk) disable iff (rst)
        init_we |-> (port_gnt[0] == '0));
endmodule

bind wstream_top wstream_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .stream_en (stream_en),
    .init_we   (init_we),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .port_gnt  (port_gnt),
    .lane_fill (lane_fill)
);

// File: tb/wstream_top_tb_top.sv
`timescale 1ns/1ps
module wstream_top_tb_top;
    import wstream_pkg::*;

    logic                   clk = 1'b0;
    logic                   rst;
    logic                   stream_en;
    logic                   init_we;
    logic [ADDR_W-1:0]      init_addr;
    logic [DATA_W-1:0]      init_data;
    logic [NOUT-1:0]        rdy;
    logic [NOUT-1:0]        out_valid;
    logic [NOUT*DATA_W-1:0] out_data;

    int errors = 0;
    int checks = 0;
    int mode   = 0;       // 0 all ready, 1 random, 2 stream0 stalled
    bit mon_on = 1'b0;
    bit saw_valid;
    bit done   = 1'b0;
    int fires    [NOUT];
    int exp_k    [NOUT];
    bit first    [NOUT];
    bit prev_stall [NOUT];
    logic [DATA_W-1:0] prev_d [NOUT];

    always #4 clk = ~clk;

    wstream_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .stream_en (stream_en),
        .init_we   (init_we),
        .init_addr (init_addr),
        .init_data (init_data),
        .out_ready (rdy),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic int blen(input int b);
        return (b == 0) ? 10 : (b == 1) ? 7 : 4;
    endfunction

    function automatic logic [7:0] wval(input int b, input int k);
        return 8'((b * 67 + k * 29 + 3) % 256);
    endfunction

    // layout from R2 and R3
    function automatic logic [7:0] ram_word(input int a);
        if (a < 5)               return wval(0, 2 * a);
        if (a >= 8 && a <= 14)   return wval(1, a - 8);
        if (a >= 16 && a <= 20)  return wval(0, 2 * (a - 16) + 1);
        if (a >= 24 && a <= 27)  return wval(2, a - 24);
        return 8'hEE;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // reference model: per stream expected word index, compared every clock
    always begin
        @(negedge clk);
        if (mon_on) begin
            case (mode)
                0: rdy = '1;
                1: for (int o = 0; o < NOUT; o++) rdy[o] = (($urandom % 4) != 0);
                2: rdy = 3'b110;
                default: rdy = '0;
            endcase
            #1;
            if (out_valid != '0) saw_valid = 1'b1;
            for (int o = 0; o < NOUT; o++) begin
                logic [7:0] d;
                d = out_data[o*DATA_W +: DATA_W];
                if (prev_stall[o]) begin
                    chk(out_valid[o] && d == prev_d[o], $sformatf("R4 hold stream%0d", o),
                        int'(d), int'(prev_d[o]));
                end
                if (out_valid[o] && rdy[o]) begin
                    if (!first[o]) begin
                        chk(d == wval(o, 0), $sformatf("R1 first word stream%0d", o),
                            int'(d), int'(wval(o, 0)));
                        first[o] = 1'b1;
                    end
                    chk(d == wval(o, exp_k[o]),
                        $sformatf("%s stream%0d word%0d", (o == 0) ? "R3 R7" : "R2 R7", o, exp_k[o]),
                        int'(d), int'(wval(o, exp_k[o])));
                    exp_k[o] = (exp_k[o] + 1) % blen(o);
                    fires[o]++;
                end
                prev_stall[o] = out_valid[o] && !rdy[o];
                prev_d[o]     = d;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; stream_en = 1'b0; init_we = 1'b0;
        init_addr = '0; init_data = '0; rdy = '1;
        for (int o = 0; o < NOUT; o++) begin
            fires[o] = 0; exp_k[o] = 0; first[o] = 1'b0;
            prev_stall[o] = 1'b0; prev_d[o] = '0;
        end
        repeat (5) @(negedge clk);
        chk(out_valid == '0, "R1 valid low in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        #2;
        chk(out_valid == '0, "R1 valid low after reset", int'(out_valid), 0);

        // preload, streaming off
        mon_on = 1'b1;
        saw_valid = 1'b0;
        for (int a = 0; a < 32; a++) begin
            @(negedge clk);
            init_we = 1'b1; init_addr = ADDR_W'(a); init_data = ram_word(a);
        end
        @(negedge clk);
        init_we = 1'b0;
        repeat (20) @(negedge clk);
        chk(!saw_valid, "R8 no output while disabled", int'(saw_valid), 0);

        // fair service with all ready
        mode = 0;
        stream_en = 1'b1;
        repeat (50) @(negedge clk);
        for (int o = 0; o < NOUT; o++) fires[o] = 0;
        repeat (200) @(negedge clk);
        chk(fires[0] >= 190 && fires[0] <= 200, "R5 stream0 rate", fires[0], 200);
        chk(fires[1] >= 95 && fires[1] <= 105, "R5 stream1 rate", fires[1], 100);
        chk(fires[2] >= 95 && fires[2] <= 105, "R5 stream2 rate", fires[2], 100);

        // preload write during streaming blocks port A only
        init_we = 1'b1; init_addr = ADDR_W'(31); init_data = 8'hEE;
        repeat (8) @(negedge clk);
        for (int o = 0; o < NOUT; o++) fires[o] = 0;
        repeat (12) @(negedge clk);
        chk(fires[1] == 0, "R9 port A reads held", fires[1], 0);
        chk(fires[2] >= 5, "R9 port B reads continue", fires[2], 6);
        init_we = 1'b0;

        // adaptive slot reuse with stream 0 stalled
        mode = 2;
        repeat (40) @(negedge clk);
        for (int o = 0; o < NOUT; o++) fires[o] = 0;
        repeat (200) @(negedge clk);
        chk(fires[0] == 0, "R6 stalled stream idle", fires[0], 0);
        chk(fires[1] >= 190, "R6 stream1 takes slots", fires[1], 200);
        chk(fires[2] >= 190, "R6 stream2 takes slots", fires[2], 200);

        // random backpressure, data compared every clock by the model
        mode = 1;
        for (int o = 0; o < NOUT; o++) fires[o] = 0;
        repeat (3000) @(negedge clk);
        chk(fires[0] >= 300, "R7 stream0 progress", fires[0], 300);
        chk(fires[1] >= 300, "R7 stream1 progress", fires[1], 300);
        chk(fires[2] >= 300, "R7 stream2 progress", fires[2], 300);

        // disable and drain
        mode = 0;
        stream_en = 1'b0;
        repeat (30) @(negedge clk);
        saw_valid = 1'b0;
        for (int o = 0; o < NOUT; o++) fires[o] = 0;
        repeat (50) @(negedge clk);
        chk(!saw_valid, "R8 drained and idle", int'(saw_valid), 0);
        chk(fires[0] + fires[1] + fires[2] == 0, "R8 no words after drain",
            fires[0] + fires[1] + fires[2], 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule